// File: doc/BRIEF.md
# Partial-Tag Snoop Filter

This block sits next to one core's private data cache in a four-core, bus-based cache system. It holds a shadow copy of the three remote caches' tag arrays. Each remote cache is 4-way set associative, and each shadow entry keeps only a short slice of the tag: the lowest tag bits, with a valid flag and a dirty flag. When the local cache misses, the request address goes through the filter before any snoop goes onto the bus. The filter compares the short tag against every shadow way of the indexed set, in every remote core.

If nothing matches, no remote cache can hold the line. The filter then reports that no snoop is needed, and the request can go straight to the upper-level cache. If something matches, a per-core mask names the remote caches that might hold the line, so only those caches are snooped. A partial match can be a false hit, which only costs a useless snoop. A false miss cannot occur, because any copy a remote cache really holds has a matching partial tag.

The shadow contents follow broadcast fill messages, which give the owning core, the way, the address and a dirty flag. They also follow invalidation messages, which give the core, the set and the way. Fills announced by the local core are dropped, because the filter only mirrors remote caches.

Top module: `partial_tag_snoop_filter`

## Requirements
- R1: Reset marks every shadow entry invalid and holds `resp_valid`, `snoop_needed`, `dirty_hint`, `target_mask` and `req_ready` low. `req_ready` rises on the first clock edge after reset is released. Until a fill arrives, every lookup reports no snoop.
- R2: Address fields are fixed. The line offset is bits [5:0] and the set index is bits [11:6]. The partial tag is the 8 bits directly above the index, bits [19:12]. A lookup only examines shadow entries of its own set.
- R3: A lookup accepted on a clock edge (`req_valid` and `req_ready` both high) produces `resp_valid` high with its result on the next edge. A new lookup may be accepted on every cycle.
- R4: If no valid shadow entry of the indexed set in any remote core holds the request's partial tag, `snoop_needed` is 0 and `target_mask` is all zeros.
- R5: `target_mask` bit k is 1 exactly when remote core k holds a valid matching entry in the indexed set. Remote cores are numbered in ascending core id with the local core skipped. With local id 0, bit 0 is core 1, bit 1 is core 2 and bit 2 is core 3. `snoop_needed` is 1 exactly when the mask is non-zero.
- R6: Tag bits above the partial tag (bits [31:20]) have no effect on matching. Two addresses that agree in set and partial tag produce the same result.
- R7: A fill writes the address's partial tag and its dirty flag into the named remote core's entry at the address's set and the given way, and sets that entry valid. Any earlier contents are replaced. `dirty_hint` is 1 when at least one matching entry was filled dirty.
- R8: A fill whose core id equals the local core id changes no shadow entry.
- R9: An invalidation naming core, set and way clears that entry's valid flag. Later lookups no longer match it.
- R10: A lookup accepted in the same cycle as a fill or invalidation sees the shadow contents from before that update. The update is visible from the next cycle.
- R11: If a fill and an invalidation target the same entry in the same cycle, the fill wins and the entry ends up valid.
- R12: In a cycle after one where no lookup was accepted, `resp_valid`, `snoop_needed`, `dirty_hint` and `target_mask` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request valid |
| req_addr | input | 32 | Address of the local miss |
| req_ready | output | 1 | Filter accepts lookups |
| resp_valid | output | 1 | Lookup result valid |
| snoop_needed | output | 1 | At least one remote core may hold the line |
| dirty_hint | output | 1 | A matching remote entry was filled dirty |
| target_mask | output | 3 | Per-remote-core snoop targets |
| fill_valid | input | 1 | Fill message valid |
| fill_addr | input | 32 | Address of the filled line |
| fill_core | input | 2 | Core that received the line |
| fill_way | input | 2 | Way written in that core |
| fill_dirty | input | 1 | Line filled in dirty state |
| inval_valid | input | 1 | Invalidation message valid |
| inval_core | input | 2 | Core that dropped a line |
| inval_set | input | 6 | Set of the dropped line |
| inval_way | input | 2 | Way of the dropped line |

## Verification
The checker watches four things on every cycle:
- Each accepted lookup yields a response one cycle later.
- The result outputs are all zero in the cycle after an idle one.
- `snoop_needed` always agrees with whether the mask is non-zero.
- `dirty_hint` never appears without a snoop target, and all outputs are quiet while reset is applied.

The content-dependent behaviours can only be shown by the bench's directed scenarios:
- which cores match, and partial-tag aliasing across high tag bits;
- replacement on refill and invalidation;
- dropping of local fills;
- the pre-update view of a same-cycle lookup, and fill-over-invalidate priority.

// File: rtl/psf_pkg.sv
package psf_pkg;
  localparam int PSF_CORES    = 4;
  localparam int PSF_WAYS     = 4;
  localparam int PSF_ADDR_W   = 32;
  localparam int PSF_OFFSET_W = 6;
  localparam int PSF_SET_W    = 6;
  localparam int PSF_PTAG_W   = 8;

  // Remote slot s maps to core id s, or s+1 once the local id is passed.
  function automatic int slot_core(input int slot, input int local_id);
    return (slot < local_id) ? slot : slot + 1;
  endfunction
endpackage

// File: rtl/psf_route.sv
module psf_route #(
  parameter int NUM_CORES  = 4,
  parameter int LOCAL_CORE = 0,
  parameter int CORE_W     = 2,
  parameter int REMOTE     = NUM_CORES - 1
) (
  input  logic              fill_valid,
  input  logic [CORE_W-1:0] fill_core,
  input  logic              inval_valid,
  input  logic [CORE_W-1:0] inval_core,
  output logic [REMOTE-1:0] fill_sel,
  output logic [REMOTE-1:0] inval_sel
);
  for (genvar s = 0; s < REMOTE; s++) begin : g_slot
    localparam int CID = psf_pkg::slot_core(s, LOCAL_CORE);
    // A local core id never equals any CID, so local fills select nothing.
    assign fill_sel[s]  = fill_valid  && (fill_core  == CORE_W'(CID));
    assign inval_sel[s] = inval_valid && (inval_core == CORE_W'(CID));
  end
endmodule

// File: rtl/psf_bank.sv
module psf_bank #(
  parameter int SET_W  = 6,
  parameter int WAYS   = 4,
  parameter int WAY_W  = 2,
  parameter int PTAG_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SET_W-1:0]  rd_set,
  input  logic [PTAG_W-1:0] rd_ptag,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [PTAG_W-1:0] wr_ptag,
  input  logic              wr_dirty,
  input  logic              clr_en,
  input  logic [SET_W-1:0]  clr_set,
  input  logic [WAY_W-1:0]  clr_way,
  output logic              match,
  output logic              match_dirty
);
  localparam int SETS = 1 << SET_W;

  logic [WAYS-1:0] way_hit;
  logic [WAYS-1:0] way_dirty;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    // {dirty, partial tag}; no reset so it maps onto distributed RAM
    logic [PTAG_W:0]   ram [SETS];
    logic [SETS-1:0]   vld;
    logic [PTAG_W:0]   rd_word;
    logic              wr_hit;
    logic              clr_hit;

    assign wr_hit  = wr_en  && (wr_way  == WAY_W'(w));
    assign clr_hit = clr_en && (clr_way == WAY_W'(w));

    always_ff @(posedge clk) begin
      if (wr_hit) ram[wr_set] <= {wr_dirty, wr_ptag};
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        vld <= '0;
      end else begin
        if (clr_hit) vld[clr_set] <= 1'b0;
        if (wr_hit)  vld[wr_set]  <= 1'b1;   // later write: fill wins
      end
    end

    assign rd_word      = ram[rd_set];
    assign way_hit[w]   = vld[rd_set] && (rd_word[PTAG_W-1:0] == rd_ptag);
    assign way_dirty[w] = rd_word[PTAG_W];
  end

  assign match       = |way_hit;
  assign match_dirty = |(way_hit & way_dirty);
endmodule

// File: rtl/partial_tag_snoop_filter.sv
module partial_tag_snoop_filter #(
  parameter int NUM_CORES  = psf_pkg::PSF_CORES,
  parameter int LOCAL_CORE = 0,
  parameter int WAYS       = psf_pkg::PSF_WAYS,
  parameter int ADDR_W     = psf_pkg::PSF_ADDR_W,
  parameter int OFFSET_W   = psf_pkg::PSF_OFFSET_W,
  parameter int SET_W      = psf_pkg::PSF_SET_W,
  parameter int PTAG_W     = psf_pkg::PSF_PTAG_W,
  parameter int REMOTE     = NUM_CORES - 1,
  parameter int CORE_W     = $clog2(NUM_CORES),
  parameter int WAY_W      = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              resp_valid,
  output logic              snoop_needed,
  output logic              dirty_hint,
  output logic [REMOTE-1:0] target_mask,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [CORE_W-1:0] fill_core,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic              fill_dirty,
  input  logic              inval_valid,
  input  logic [CORE_W-1:0] inval_core,
  input  logic [SET_W-1:0]  inval_set,
  input  logic [WAY_W-1:0]  inval_way
);
  localparam int SET_LO = OFFSET_W;
  localparam int TAG_LO = OFFSET_W + SET_W;

  logic [SET_W-1:0]  req_set, fill_set;
  logic [PTAG_W-1:0] req_ptag, fill_ptag;
  logic [REMOTE-1:0] fill_sel, inval_sel;
  logic [REMOTE-1:0] core_match, core_dirty;
  logic              accept;

  assign req_set   = req_addr[SET_LO +: SET_W];
  assign req_ptag  = req_addr[TAG_LO +: PTAG_W];
  assign fill_set  = fill_addr[SET_LO +: SET_W];
  assign fill_ptag = fill_addr[TAG_LO +: PTAG_W];
  assign accept    = req_valid && req_ready;

  logic unused_addr_bits;
  assign unused_addr_bits = ^{req_addr[SET_LO-1:0], req_addr[ADDR_W-1:TAG_LO+PTAG_W],
                              fill_addr[SET_LO-1:0], fill_addr[ADDR_W-1:TAG_LO+PTAG_W]};

  psf_route #(
    .NUM_CORES(NUM_CORES), .LOCAL_CORE(LOCAL_CORE), .CORE_W(CORE_W), .REMOTE(REMOTE)
  ) u_route (
    .fill_valid (fill_valid),
    .fill_core  (fill_core),
    .inval_valid(inval_valid),
    .inval_core (inval_core),
    .fill_sel   (fill_sel),
    .inval_sel  (inval_sel)
  );

  for (genvar s = 0; s < REMOTE; s++) begin : g_bank
    psf_bank #(
      .SET_W(SET_W), .WAYS(WAYS), .WAY_W(WAY_W), .PTAG_W(PTAG_W)
    ) u_bank (
      .clk        (clk),
      .rst        (rst),
      .rd_set     (req_set),
      .rd_ptag    (req_ptag),
      .wr_en      (fill_sel[s]),
      .wr_set     (fill_set),
      .wr_way     (fill_way),
      .wr_ptag    (fill_ptag),
      .wr_dirty   (fill_dirty),
      .clr_en     (inval_sel[s]),
      .clr_set    (inval_set),
      .clr_way    (inval_way),
      .match      (core_match[s]),
      .match_dirty(core_dirty[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready    <= 1'b0;
      resp_valid   <= 1'b0;
      snoop_needed <= 1'b0;
      dirty_hint   <= 1'b0;
      target_mask  <= '0;
    end else begin
      req_ready    <= 1'b1;
      resp_valid   <= accept;
      target_mask  <= accept ? core_match : '0;
      snoop_needed <= accept && (|core_match);
      dirty_hint   <= accept && (|core_dirty);
    end
  end
endmodule

// File: rtl/psf_checker.sv
module psf_checker #(
  parameter int REMOTE = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              snoop_needed,
  input logic              dirty_hint,
  input logic [REMOTE-1:0] target_mask
);
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    rst |=> (!resp_valid && !snoop_needed && !dirty_hint && target_mask == '0 && !req_ready));

  a_r3_resp_follows_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> resp_valid);

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> (!resp_valid && !snoop_needed && !dirty_hint && target_mask == '0));

  a_r5_snoop_agrees_mask: assert property (@(posedge clk) disable iff (rst)
    snoop_needed == (target_mask != '0));

  a_r7_dirty_needs_target: assert property (@(posedge clk) disable iff (rst)
    dirty_hint |-> (snoop_needed && resp_valid));
endmodule

bind partial_tag_snoop_filter psf_checker #(.REMOTE(REMOTE)) u_psf_checker (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .resp_valid  (resp_valid),
  .snoop_needed(snoop_needed),
  .dirty_hint  (dirty_hint),
  .target_mask (target_mask)
);

// File: tb/partial_tag_snoop_filter_bench.sv
module partial_tag_snoop_filter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready, resp_valid, snoop_needed, dirty_hint;
  logic [2:0]  target_mask;
  logic        fill_valid = 1'b0;
  logic [31:0] fill_addr = '0;
  logic [1:0]  fill_core = '0;
  logic [1:0]  fill_way = '0;
  logic        fill_dirty = 1'b0;
  logic        inval_valid = 1'b0;
  logic [1:0]  inval_core = '0;
  logic [5:0]  inval_set = '0;
  logic [1:0]  inval_way = '0;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  partial_tag_snoop_filter u_partial_tag_snoop_filter (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .resp_valid(resp_valid), .snoop_needed(snoop_needed),
    .dirty_hint(dirty_hint), .target_mask(target_mask),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_core(fill_core),
    .fill_way(fill_way), .fill_dirty(fill_dirty),
    .inval_valid(inval_valid), .inval_core(inval_core),
    .inval_set(inval_set), .inval_way(inval_way)
  );

  function automatic logic [31:0] mk(input logic [11:0] hi, input logic [7:0] pt,
                                     input logic [5:0] set);
    return {hi, pt, set, 6'h00};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [31:0] a, input logic [1:0] core, input logic [1:0] way,
                      input logic dirty);
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = a; fill_core = core; fill_way = way; fill_dirty = dirty;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic inval(input logic [1:0] core, input logic [5:0] set, input logic [1:0] way);
    @(negedge clk);
    inval_valid = 1'b1; inval_core = core; inval_set = set; inval_way = way;
    @(negedge clk);
    inval_valid = 1'b0;
  endtask

  task automatic lookup(input string req, input logic [31:0] a, input logic [2:0] exp_mask,
                        input logic exp_dirty);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " resp_valid"}, 32'(resp_valid), 32'd1);
    chk({req, " target_mask"}, 32'(target_mask), 32'(exp_mask));
    chk({req, " snoop_needed"}, 32'(snoop_needed), 32'(exp_mask != 3'b000));
    chk({req, " dirty_hint"}, 32'(dirty_hint), 32'(exp_dirty));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 req_ready after reset", 32'(req_ready), 32'd1);
    chk("R1 resp_valid after reset", 32'(resp_valid), 32'd0);
    lookup("R1 R4 empty filter", mk(12'h000, 8'h55, 6'd5), 3'b000, 1'b0);
  endtask

  task automatic t_match_and_alias();
    fill(mk(12'h001, 8'hA5, 6'd3), 2'd2, 2'd1, 1'b0);
    lookup("R5 R7 core2 hit", mk(12'h001, 8'hA5, 6'd3), 3'b010, 1'b0);
    fill(mk(12'h007, 8'hA5, 6'd3), 2'd3, 2'd2, 1'b1);
    lookup("R6 alias two cores", mk(12'h009, 8'hA5, 6'd3), 3'b110, 1'b1);
    lookup("R2 other set misses", mk(12'h001, 8'hA5, 6'd4), 3'b000, 1'b0);
    lookup("R4 other ptag misses", mk(12'h001, 8'hA4, 6'd3), 3'b000, 1'b0);
  endtask

  task automatic t_local_fill();
    fill(mk(12'h000, 8'h3C, 6'd10), 2'd0, 2'd0, 1'b1);
    lookup("R8 local fill ignored", mk(12'h000, 8'h3C, 6'd10), 3'b000, 1'b0);
  endtask

  task automatic t_replace_and_inval();
    fill(mk(12'h001, 8'h11, 6'd3), 2'd2, 2'd1, 1'b0);
    lookup("R7 replaced entry gone", mk(12'h001, 8'hA5, 6'd3), 3'b100, 1'b1);
    lookup("R7 new entry present", mk(12'h001, 8'h11, 6'd3), 3'b010, 1'b0);
    inval(2'd3, 6'd3, 2'd2);
    lookup("R9 invalidated entry", mk(12'h001, 8'hA5, 6'd3), 3'b000, 1'b0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = mk(12'h002, 8'h77, 6'd20); fill_core = 2'd1;
    fill_way = 2'd3; fill_dirty = 1'b0;
    req_valid = 1'b1; req_addr = mk(12'h002, 8'h77, 6'd20);
    @(negedge clk);
    fill_valid = 1'b0; req_valid = 1'b0;
    chk("R10 same-cycle resp_valid", 32'(resp_valid), 32'd1);
    chk("R10 same-cycle sees old", 32'(target_mask), 32'd0);
    lookup("R10 update visible next", mk(12'h002, 8'h77, 6'd20), 3'b001, 1'b0);
  endtask

  task automatic t_fill_vs_inval();
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = mk(12'h000, 8'h99, 6'd21); fill_core = 2'd1;
    fill_way = 2'd0; fill_dirty = 1'b1;
    inval_valid = 1'b1; inval_core = 2'd1; inval_set = 6'd21; inval_way = 2'd0;
    @(negedge clk);
    fill_valid = 1'b0; inval_valid = 1'b0;
    lookup("R11 fill wins", mk(12'h000, 8'h99, 6'd21), 3'b001, 1'b1);
  endtask

  task automatic t_back_to_back();
    for (int w = 0; w < 4; w++) fill(mk(12'h0F0, 8'(8'h10 + w), 6'd40), 2'd3, 2'(w), 1'b0);
    @(negedge clk);
    for (int w = 0; w < 5; w++) begin
      req_valid = 1'b1;
      req_addr  = mk(12'h000, 8'(8'h10 + w), 6'd40);
      @(negedge clk);
      chk("R3 back-to-back resp_valid", 32'(resp_valid), 32'd1);
      chk("R3 back-to-back mask", 32'(target_mask), (w < 4) ? 32'd4 : 32'd0);
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk("R12 idle resp_valid", 32'(resp_valid), 32'd0);
    chk("R12 idle mask", 32'(target_mask), 32'd0);
    chk("R12 idle snoop", 32'(snoop_needed), 32'd0);
  endtask

  initial begin
    t_reset();
    t_match_and_alias();
    t_local_fill();
    t_replace_and_inval();
    t_same_cycle();
    t_fill_vs_inval();
    t_back_to_back();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule